// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter

This block turns bytes written into a small holding queue into asynchronous serial frames on a single output line. A frame starts with one low start bit. Then come the data bits, least significant first, with a length of six, seven or eight bits. An optional even or odd parity bit may follow. The frame ends with one high stop bit. Every bit lasts a whole number of system clock cycles, set by a baud divisor input.

Permission to send can come from two places. With hardware flow control off, a configuration bit grants it and the clear-to-send input has no effect. With flow control on, the active-low clear-to-send input grants it. That input passes through a two-flop synchronizer. The transmitter checks it only between frames, so a frame that has started always runs through its stop bit, even if clear-to-send is withdrawn part way through.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset `txd` is 1, `txBusy` is 0, `fifoFull` is 0 and `fifoLevel` is 0.
- R2: A frame drives `txd` low for the start bit, then the data bits LSB first, then high for the stop bit.
- R3: `cfgWordLen` selects the data bit count: 0 gives 6 bits, 1 gives 7 bits, 2 or 3 gives 8 bits. Written bits above the selected count are never sent.
- R4: With `cfgParityEn` at 1, one parity bit follows the last data bit. It is computed over the sent data bits only. With `cfgParityOdd` at 0 the number of ones in data plus parity is even. With `cfgParityOdd` at 1 that number is odd.
- R5: The queue holds 4 entries in first-in first-out order. `fifoLevel` gives the entry count and `fifoFull` is 1 at 4 entries. A write while full is discarded.
- R6: With `cfgFlowEn` at 0, a frame starts only while `cfgTxEnable` is 1, and `ctsN` has no effect.
- R7: With `cfgFlowEn` at 1, queued data is held while `ctsN` is 1 (regardless of `cfgTxEnable`), and is sent once `ctsN` is 0.
- R8: If `ctsN` rises during a frame, that frame completes through its stop bit, and the next queued frame waits.
- R9: `txBusy` is 1 from the start bit to the end of the stop bit. `txd` is 1 whenever `txBusy` is 0.
- R10: Each bit lasts exactly `cfgBaudDiv` clock cycles. For example, the start bit is low for `cfgBaudDiv` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Write strobe for the queue |
| wrData | input | 8 | Byte to queue |
| fifoFull | output | 1 | Queue holds 4 entries |
| fifoLevel | output | 3 | Number of queued entries |
| cfgWordLen | input | 2 | Data length select |
| cfgParityEn | input | 1 | Append parity bit |
| cfgParityOdd | input | 1 | 1 selects odd parity, 0 even |
| cfgFlowEn | input | 1 | Hardware flow control on |
| cfgTxEnable | input | 1 | Transmit grant when flow control is off |
| cfgBaudDiv | input | 16 | Clock cycles per bit (1 or more) |
| ctsN | input | 1 | Active-low clear-to-send |
| txd | output | 1 | Serial output, idles high |
| txBusy | output | 1 | A frame is on the line |

## Verification
The hardest case to reach is clear-to-send being withdrawn while a frame is in progress, with a second byte already queued behind it. The stimulus first holds `ctsN` high while it queues two bytes. It then lowers `ctsN` and, in parallel with a bit-level line receiver, raises `ctsN` again ten cycles into the first frame. Finally it checks three things: the first frame arrives whole, the second stays queued with the line idle, and the second goes out once `ctsN` drops again.

// File: rtl/uctx_pkg.sv
package uctx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } txState_e;

  typedef struct packed {
    logic load;
    logic shiftBit;
    logic emitParity;
    logic emitStop;
  } txStrobes_t;
endpackage

// File: rtl/uctx_fifo.sv
module uctx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [DW-1:0] pushData,
  input  logic          pop,
  output logic [DW-1:0] headData,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [LW-1:0] count;
  logic doPush, doPop;

  assign full     = (count == LW'(DEPTH));
  assign empty    = (count == '0);
  assign level    = count;
  assign headData = mem[rdPtr];
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (level == $past(level)));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> (level == '0));
endmodule

// File: rtl/uctx_ctrl.sv
module uctx_ctrl
  import uctx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 16,
  localparam int CW  = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fifoEmpty,
  input  logic [1:0]      cfgWordLen,
  input  logic            cfgParityEn,
  input  logic            cfgFlowEn,
  input  logic            cfgTxEnable,
  input  logic [DIVW-1:0] cfgBaudDiv,
  input  logic            ctsN,
  output txStrobes_t      strobes,
  output logic [CW-1:0]   frameBits,
  output logic            txBusy
);
  txState_e state, stNext;
  logic ctsMeta, ctsSync;
  logic txAllowed;
  logic [DIVW-1:0] baudCnt, divEff;
  logic bitEnd;
  logic [CW-1:0] bitIdx, lastBit;
  logic parEnQ;

  // two-flop synchronizer, reset to the deasserted (high) level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsMeta <= 1'b1;
      ctsSync <= 1'b1;
    end else begin
      ctsMeta <= ctsN;
      ctsSync <= ctsMeta;
    end
  end

  assign txAllowed = cfgFlowEn ? !ctsSync : cfgTxEnable;
  assign frameBits = cfgWordLen[1] ? CW'(DW) : CW'(DW - 2) + CW'(cfgWordLen[0]);
  assign divEff    = (cfgBaudDiv == '0) ? DIVW'(1) : cfgBaudDiv;
  assign bitEnd    = (baudCnt == divEff - DIVW'(1));
  assign txBusy    = (state != ST_IDLE);

  always_comb begin
    strobes = '0;
    stNext  = state;
    unique case (state)
      ST_IDLE: if (!fifoEmpty && txAllowed) begin
        strobes.load = 1'b1;
        stNext = ST_START;
      end
      ST_START: if (bitEnd) begin
        strobes.shiftBit = 1'b1;
        stNext = ST_DATA;
      end
      ST_DATA: if (bitEnd) begin
        if (bitIdx == lastBit) begin
          if (parEnQ) begin
            strobes.emitParity = 1'b1;
            stNext = ST_PARITY;
          end else begin
            strobes.emitStop = 1'b1;
            stNext = ST_STOP;
          end
        end else begin
          strobes.shiftBit = 1'b1;
        end
      end
      ST_PARITY: if (bitEnd) begin
        strobes.emitStop = 1'b1;
        stNext = ST_STOP;
      end
      ST_STOP: if (bitEnd) stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      baudCnt <= '0;
      bitIdx  <= '0;
      lastBit <= '0;
      parEnQ  <= 1'b0;
    end else begin
      state   <= stNext;
      baudCnt <= (state == ST_IDLE || bitEnd) ? '0 : baudCnt + 1'b1;
      if (strobes.load) begin
        bitIdx  <= '0;
        lastBit <= frameBits - 1'b1;
        parEnQ  <= cfgParityEn;
      end else if (state == ST_DATA && strobes.shiftBit) begin
        bitIdx  <= bitIdx + 1'b1;
      end
    end
  end

  assert_cts_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cfgFlowEn && ctsSync) |=> (state == ST_IDLE));
  assert_finish_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && cfgFlowEn && ctsSync) |=> (state != ST_IDLE));
endmodule

// File: rtl/uctx_datapath.sv
module uctx_datapath
  import uctx_pkg::*;
#(
  parameter int DW  = 8,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  txStrobes_t    strobes,
  input  logic [DW-1:0] fifoData,
  input  logic [CW-1:0] frameBits,
  input  logic          cfgParityOdd,
  output logic          txd
);
  logic [DW-1:0] shReg, mask, masked;
  logic parBit;

  always_comb begin
    for (int i = 0; i < DW; i++) mask[i] = (CW'(i) < frameBits);
  end
  assign masked = fifoData & mask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      parBit <= 1'b0;
      txd    <= 1'b1;
    end else begin
      if (strobes.load) begin
        shReg  <= masked;
        parBit <= (^masked) ^ cfgParityOdd;
        txd    <= 1'b0;
      end else if (strobes.shiftBit) begin
        txd    <= shReg[0];
        shReg  <= shReg >> 1;
      end else if (strobes.emitParity) begin
        txd    <= parBit;
      end else if (strobes.emitStop) begin
        txd    <= 1'b1;
      end
    end
  end

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uctx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int DIVW  = 16,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int CW   = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrValid,
  input  logic [DW-1:0]   wrData,
  output logic            fifoFull,
  output logic [LW-1:0]   fifoLevel,
  input  logic [1:0]      cfgWordLen,
  input  logic            cfgParityEn,
  input  logic            cfgParityOdd,
  input  logic            cfgFlowEn,
  input  logic            cfgTxEnable,
  input  logic [DIVW-1:0] cfgBaudDiv,
  input  logic            ctsN,
  output logic            txd,
  output logic            txBusy
);
  txStrobes_t strobes;
  logic [DW-1:0] headData;
  logic fifoEmpty;
  logic [CW-1:0] frameBits;

  uctx_fifo #(.DW(DW), .DEPTH(DEPTH)) uFifo (
    .clk(clk), .rstN(rstN), .push(wrValid), .pushData(wrData),
    .pop(strobes.load), .headData(headData), .empty(fifoEmpty),
    .full(fifoFull), .level(fifoLevel)
  );

  uctx_ctrl #(.DW(DW), .DIVW(DIVW)) uCtrl (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .cfgWordLen(cfgWordLen),
    .cfgParityEn(cfgParityEn), .cfgFlowEn(cfgFlowEn), .cfgTxEnable(cfgTxEnable),
    .cfgBaudDiv(cfgBaudDiv), .ctsN(ctsN), .strobes(strobes),
    .frameBits(frameBits), .txBusy(txBusy)
  );

  uctx_datapath #(.DW(DW)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fifoData(headData),
    .frameBits(frameBits), .cfgParityOdd(cfgParityOdd), .txd(txd)
  );

  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txd);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txd);
endmodule

// File: tb/tb_uart_cts_tx.sv
module tb_uart_cts_tx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic fifoFull;
  logic [2:0] fifoLevel;
  logic [1:0] cfgWordLen = 2'd2;
  logic cfgParityEn = 1'b0, cfgParityOdd = 1'b0, cfgFlowEn = 1'b0, cfgTxEnable = 1'b1;
  logic [15:0] cfgBaudDiv = 16'd4;
  logic ctsN = 1'b0;
  logic txd, txBusy;
  int nChecks = 0, nFails = 0;

  always #10 clk = ~clk;

  uart_cts_tx dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .fifoFull(fifoFull), .fifoLevel(fifoLevel), .cfgWordLen(cfgWordLen),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd), .cfgFlowEn(cfgFlowEn),
    .cfgTxEnable(cfgTxEnable), .cfgBaudDiv(cfgBaudDiv), .ctsN(ctsN),
    .txd(txd), .txBusy(txBusy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk); wrValid = 1'b1; wrData = b;
    @(negedge clk); wrValid = 1'b0;
  endtask

  task automatic rxFrame(input int nb, input bit pe, output int data, output int par,
                         output int startV, output int stopV, output bit ok);
    int w = 0;
    int div = int'(cfgBaudDiv);
    ok = 0; data = 0; par = 0; startV = 1; stopV = 0;
    do begin @(negedge clk); w++; end while (txd !== 1'b0 && w < 3000);
    if (w >= 3000) return;
    ok = 1;
    repeat (div / 2) @(negedge clk);
    startV = int'(txd);
    for (int i = 0; i < nb; i++) begin
      repeat (div) @(negedge clk);
      data |= int'(txd) << i;
    end
    if (pe) begin repeat (div) @(negedge clk); par = int'(txd); end
    repeat (div) @(negedge clk);
    stopV = int'(txd);
  endtask

  task automatic checkFrame(input string req, input logic [7:0] b);
    int nb = (cfgWordLen >= 2) ? 8 : 6 + int'(cfgWordLen);
    int expData = int'(b) & ((1 << nb) - 1);
    int expPar = ($countones(expData) % 2) ^ int'(cfgParityOdd);
    int data, par, startV, stopV;
    bit ok;
    rxFrame(nb, cfgParityEn, data, par, startV, stopV, ok);
    check(req, "frame seen", int'(ok), 1);
    check(req, "start bit", startV, 0);
    check(req, "data bits", data, expData);
    if (cfgParityEn) check(req, "parity bit", par, expPar);
    check(req, "stop bit", stopV, 1);
  endtask

  task automatic waitIdle();
    int w = 0;
    while (txBusy && w < 3000) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "txd", int'(txd), 1);
    check("R1", "txBusy", int'(txBusy), 0);
    check("R1", "fifoFull", int'(fifoFull), 0);
    check("R1", "fifoLevel", int'(fifoLevel), 0);
  endtask

  task automatic testBasic();
    cfgWordLen = 2'd2; cfgParityEn = 0;
    pushByte(8'hA5);
    checkFrame("R2", 8'hA5);
    waitIdle();
    check("R9", "txd idle high", int'(txd), 1);
  endtask

  task automatic testWordParity();
    cfgWordLen = 2'd1; cfgParityEn = 1; cfgParityOdd = 0;
    pushByte(8'hDB);
    checkFrame("R4", 8'hDB);
    waitIdle();
    cfgWordLen = 2'd0; cfgParityOdd = 1;
    pushByte(8'hFF);
    checkFrame("R3", 8'hFF);
    waitIdle();
    cfgWordLen = 2'd3; cfgParityOdd = 0;
    pushByte(8'h80);
    checkFrame("R3", 8'h80);
    waitIdle();
    cfgParityEn = 0; cfgWordLen = 2'd2;
  endtask

  task automatic testFifo();
    cfgTxEnable = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); wrValid = 1'b1; wrData = 8'(8'h30 + i);
    end
    @(negedge clk); wrValid = 1'b0;
    repeat (40) @(negedge clk);
    check("R5", "fifoLevel full", int'(fifoLevel), 4);
    check("R5", "fifoFull", int'(fifoFull), 1);
    check("R6", "held with enable low", int'(txBusy), 0);
    check("R6", "txd held high", int'(txd), 1);
    cfgTxEnable = 1;
    for (int i = 0; i < 4; i++) checkFrame("R5", 8'(8'h30 + i));
    waitIdle();
    repeat (60) @(negedge clk);
    check("R5", "overflow write dropped", int'(txBusy), 0);
    check("R5", "fifoLevel drained", int'(fifoLevel), 0);
  endtask

  task automatic testCtsHold();
    cfgFlowEn = 1; cfgTxEnable = 1; ctsN = 1;
    pushByte(8'h3C);
    repeat (60) @(negedge clk);
    check("R7", "no start while cts high", int'(txBusy), 0);
    check("R7", "queued entry kept", int'(fifoLevel), 1);
    ctsN = 0;
    checkFrame("R7", 8'h3C);
    waitIdle();
  endtask

  task automatic testCtsMidFrame();
    ctsN = 1;
    pushByte(8'h11);
    pushByte(8'h22);
    fork
      checkFrame("R8", 8'h11);
      begin
        ctsN = 0;
        while (!txBusy) @(negedge clk);
        repeat (10) @(negedge clk);
        ctsN = 1;
      end
    join
    waitIdle();
    repeat (60) @(negedge clk);
    check("R8", "next frame waits", int'(txBusy), 0);
    check("R8", "second entry kept", int'(fifoLevel), 1);
    ctsN = 0;
    checkFrame("R8", 8'h22);
    waitIdle();
  endtask

  task automatic testFlowOff();
    cfgFlowEn = 0; cfgTxEnable = 1; ctsN = 1;
    pushByte(8'h96);
    checkFrame("R6", 8'h96);
    waitIdle();
    ctsN = 0;
  endtask

  task automatic testDivisor();
    int lowCnt = 0;
    int w = 0;
    cfgBaudDiv = 16'd7;
    pushByte(8'h01);
    do begin @(negedge clk); w++; end while (txd !== 1'b0 && w < 3000);
    while (txd === 1'b0 && lowCnt < 100) begin lowCnt++; @(negedge clk); end
    check("R10", "start bit cycles", lowCnt, 7);
    waitIdle();
    pushByte(8'hC3);
    checkFrame("R10", 8'hC3);
    waitIdle();
    cfgBaudDiv = 16'd4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testWordParity();
    testFifo();
    testCtsHold();
    testCtsMidFrame();
    testFlowOff();
    testDivisor();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule